// File: doc/BRIEF.md
# Bit-Field and Leading-Count Unit

This unit performs the release-2 style bit-manipulation operations of a 32-bit integer datapath: leading-zero and leading-one counting, bit-field extraction, bit-field insertion, swapping the two bytes inside each halfword, and sign extension of a byte or a halfword. An upstream decoder supplies an operation select, the two register operands and the two 5-bit instruction fields. The unit returns one 32-bit result and a flag that marks operand combinations whose outcome is not architecturally defined.

The field decoding follows the instruction encoding. Extraction reads the first 5-bit field as the field size minus one. Insertion reads the same field as the absolute top bit of the field. The byte-shuffle group has no operand field of its own. It picks its variant from the second 5-bit field, which sits at the shift-amount position of the instruction word. The result logic is combinational. A single output register with synchronous active-low reset presents the result one clock edge after the inputs are sampled.

Top module: `bfu_bitfield_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `result` becomes 0 and `bad_operand` becomes 0 after that edge.
- R2: With `op_sel` = 0 (leading zeros), `result` is the number of zero bits of `rs_val` above its highest set bit. It is 32 when `rs_val` is 0.
- R3: With `op_sel` = 1 (leading ones), `result` is the number of one bits of `rs_val` above its highest clear bit. It is 32 when `rs_val` is all ones.
- R4: With `op_sel` = 2 (extract) and `fld_hi + fld_lo` ≤ 31, `result` holds `rs_val[fld_hi+fld_lo : fld_lo]` in its low bits, zero-filled above.
- R5: With `op_sel` = 3 (insert) and `fld_lo` ≤ `fld_hi`, `result` is `rt_val` with bits `[fld_hi:fld_lo]` replaced by the low `fld_hi-fld_lo+1` bits of `rs_val`.
- R6: An extract with `fld_hi + fld_lo` > 31 sets `bad_operand` and returns `rt_val` unchanged.
- R7: An insert with `fld_lo` > `fld_hi` sets `bad_operand` and returns `rt_val` unchanged.
- R8: With `op_sel` = 4 and `fld_lo` = 5'h02, `result` is `{rt_val[23:16], rt_val[31:24], rt_val[7:0], rt_val[15:8]}`.
- R9: With `op_sel` = 4, `fld_lo` = 5'h10 sign-extends `rt_val[7:0]` and `fld_lo` = 5'h18 sign-extends `rt_val[15:0]`.
- R10: `op_sel` = 4 with any other `fld_lo` code, and `op_sel` values 5 to 7, set `bad_operand` and return `rt_val`.
- R11: `result` and `bad_operand` change only at a rising edge. They reflect the inputs sampled at that edge. `bad_operand` is 0 for every legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 3 | Decoded operation: 0 clz, 1 clo, 2 extract, 3 insert, 4 byte shuffle |
| rs_val | input | 32 | First source operand |
| rt_val | input | 32 | Second source operand, also the insert destination |
| fld_hi | input | 5 | Size-minus-one for extract, top bit for insert |
| fld_lo | input | 5 | Field start bit, or the shuffle variant code |
| result | output | 32 | Registered result |
| bad_operand | output | 1 | Registered flag for an undefined operand combination |

## Verification
The assertions assume that every input holds a known value at each rising edge and stays stable through the cycle. They also assume that `op_sel` is read as a plain 3-bit code, so the values 5 to 7 are legal stimulus rather than excluded states. The bench changes inputs only at falling edges. It draws random field values over the full 0 to 31 range, so illegal extract and insert combinations and unknown shuffle codes occur naturally next to legal ones. Directed cases pin the boundary sums of 31 and 32 and the zero and all-ones operands. The count operands are drawn as shifted masks so that every count from 0 to 32 is reached.

// File: rtl/bfu_pkg.sv
// Shared operation codes and shuffle variant codes for the bit-field unit.
// Assumes a decoder upstream has already mapped opcodes onto these values.
package bfu_pkg;

    typedef enum logic [2:0] {
        BFU_CLZ  = 3'd0,
        BFU_CLO  = 3'd1,
        BFU_EXT  = 3'd2,
        BFU_INS  = 3'd3,
        BFU_SHUF = 3'd4
    } bfu_op_e;

    // Shuffle variants, carried in the shift-amount field position.
    localparam logic [4:0] SHF_HALF_SWAP = 5'h02;
    localparam logic [4:0] SHF_SEXT_B    = 5'h10;
    localparam logic [4:0] SHF_SEXT_H    = 5'h18;

endpackage

// File: rtl/bfu_lead_count.sv
// Leading-zero / leading-one counter built as a log-depth priority encoder.
// Each level tests the upper half of what remains and shifts it out when it
// is empty, producing one count bit per level.
// Assumes W is a power of two and at least 2.
module bfu_lead_count #(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  src,
    input  logic          count_ones,
    output logic [CW-1:0] count
);
    localparam int unsigned LG = $clog2(W);

    logic [W-1:0]  probe;
    logic [W-1:0]  stage [0:LG];
    logic [LG-1:0] zbits;

    // Leading ones are counted as leading zeros of the inverted operand.
    assign probe    = count_ones ? ~src : src;
    assign stage[0] = probe;

    // One level per count bit, from the widest span down to a single bit.
    for (genvar k = 0; k < LG; k++) begin : g_lvl
        localparam int unsigned SPAN = W >> (k + 1);
        assign zbits[LG-1-k] = ~|stage[k][W-1 -: SPAN];
        assign stage[k+1]    = zbits[LG-1-k] ? (stage[k] << SPAN) : stage[k];
    end

    // An empty operand needs the extra top count bit.
    assign count = (probe == '0) ? CW'(W) : {1'b0, zbits};

endmodule

// File: rtl/bfu_field.sv
// Bit-field extract and insert datapath with operand legality checks.
// Extract reads hi as size-minus-one; insert reads hi as the absolute top bit.
// Assumes W is a power of two.
module bfu_field #(
    parameter int unsigned W  = 32,
    parameter int unsigned FW = $clog2(W)
) (
    input  logic [W-1:0]  rs,
    input  logic [W-1:0]  rt,
    input  logic [FW-1:0] hi,
    input  logic [FW-1:0] lo,
    output logic [W-1:0]  ext_val,
    output logic [W-1:0]  ins_val,
    output logic          ext_bad,
    output logic          ins_bad
);
    localparam logic [W-1:0] ONES = '1;

    logic [FW:0]  ext_sum;
    logic [FW:0]  top_excl;
    logic [W-1:0] low_mask;
    logic [W-1:0] ins_mask;

    // Field extent and legality for both operations.
    always_comb begin
        ext_sum  = {1'b0, hi} + {1'b0, lo};
        top_excl = {1'b0, hi} + 1'b1;
        ext_bad  = ext_sum > (FW+1)'(W - 1);
        ins_bad  = lo > hi;
    end

    // Mask of hi+1 low bits; a shift by W yields zero, so the mask fills.
    always_comb begin
        low_mask = ~(ONES << top_excl);
        ins_mask = low_mask & (ONES << lo);
    end

    // Extract: align the field to bit 0 and clear everything above it.
    always_comb ext_val = (rs >> lo) & low_mask;

    // Insert: merge the shifted source into the destination under the mask.
    always_comb ins_val = (rt & ~ins_mask) | ((rs << lo) & ins_mask);

endmodule

// File: rtl/bfu_shuffle.sv
// Byte-shuffle group: byte swap inside each halfword and sign extension of
// a byte or a halfword. The variant comes from a 5-bit code.
// Assumes W is a multiple of 16.
module bfu_shuffle #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] rt,
    input  logic [4:0]   code,
    output logic [W-1:0] value,
    output logic         bad
);
    import bfu_pkg::*;

    localparam int unsigned NH = W / 16;

    logic [W-1:0] swapped;

    // Swap the two bytes of every halfword lane.
    for (genvar h = 0; h < NH; h++) begin : g_half
        assign swapped[16*h +: 8]     = rt[16*h + 8 +: 8];
        assign swapped[16*h + 8 +: 8] = rt[16*h +: 8];
    end

    // Pick the variant; unknown codes pass rt through and flag it.
    always_comb begin
        bad = 1'b0;
        unique case (code)
            SHF_HALF_SWAP: value = swapped;
            SHF_SEXT_B:    value = {{(W-8){rt[7]}}, rt[7:0]};
            SHF_SEXT_H:    value = {{(W-16){rt[15]}}, rt[15:0]};
            default: begin
                value = rt;
                bad   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bfu_bitfield_unit.sv
// Top of the bit-field and leading-count unit. Combinational operation
// logic feeds a single output register with synchronous active-low reset.
// Assumes op_sel is already decoded; codes 5..7 are treated as undefined.
module bfu_bitfield_unit #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] rs_val,
    input  logic [W-1:0] rt_val,
    input  logic [4:0]   fld_hi,
    input  logic [4:0]   fld_lo,
    output logic [W-1:0] result,
    output logic         bad_operand
);
    import bfu_pkg::*;

    localparam int unsigned CW = $clog2(W) + 1;

    bfu_op_e      op;
    logic [CW-1:0] lead_cnt;
    logic [W-1:0] ext_val;
    logic [W-1:0] ins_val;
    logic         ext_bad;
    logic         ins_bad;
    logic [W-1:0] shf_val;
    logic         shf_bad;
    logic [W-1:0] nxt_res;
    logic         nxt_bad;

    assign op = bfu_op_e'(op_sel);

    bfu_lead_count #(.W(W), .CW(CW)) u_count (
        .src        (rs_val),
        .count_ones (op_sel == BFU_CLO),
        .count      (lead_cnt)
    );

    bfu_field #(.W(W), .FW(5)) u_field (
        .rs      (rs_val),
        .rt      (rt_val),
        .hi      (fld_hi),
        .lo      (fld_lo),
        .ext_val (ext_val),
        .ins_val (ins_val),
        .ext_bad (ext_bad),
        .ins_bad (ins_bad)
    );

    bfu_shuffle #(.W(W)) u_shuffle (
        .rt    (rt_val),
        .code  (fld_lo),
        .value (shf_val),
        .bad   (shf_bad)
    );

    // Select the operation result; illegal cases return rt and raise the flag.
    always_comb begin
        nxt_res = rt_val;
        nxt_bad = 1'b0;
        case (op)
            BFU_CLZ, BFU_CLO: nxt_res = W'(lead_cnt);
            BFU_EXT: begin
                nxt_bad = ext_bad;
                nxt_res = ext_bad ? rt_val : ext_val;
            end
            BFU_INS: begin
                nxt_bad = ins_bad;
                nxt_res = ins_bad ? rt_val : ins_val;
            end
            BFU_SHUF: begin
                nxt_bad = shf_bad;
                nxt_res = shf_val;
            end
            default: nxt_bad = 1'b1;
        endcase
    end

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result      <= '0;
            bad_operand <= 1'b0;
        end else begin
            result      <= nxt_res;
            bad_operand <= nxt_bad;
        end
    end

endmodule

// File: rtl/bfu_bitfield_unit_chk.sv
// Property checker for bfu_bitfield_unit, attached by bind below.
// Assumes inputs are known and stable around each rising edge.
module bfu_bitfield_unit_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   op_sel,
    input logic [W-1:0] rs_val,
    input logic [W-1:0] rt_val,
    input logic [4:0]   fld_hi,
    input logic [4:0]   fld_lo,
    input logic [W-1:0] result,
    input logic         bad_operand
);
    logic [5:0] ext_span;
    assign ext_span = {1'b0, fld_hi} + {1'b0, fld_lo};

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !bad_operand));

    a_r2_clz_range: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd0) |=> (result <= W && !bad_operand));

    a_r2_clz_top_set: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd0 && rs_val[W-1]) |=> (result == '0));

    a_r3_clo_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd1 && !rs_val[W-1]) |=> (result == '0));

    a_r4_ext_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd2 && ext_span <= 6'd31 && fld_hi != 5'd31)
        |=> (!result[W-1] && !bad_operand));

    a_r5_ins_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd3 && fld_lo <= fld_hi && fld_lo != 5'd0)
        |=> (result[0] == $past(rt_val[0]) && !bad_operand));

    a_r6_ext_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd2 && ext_span > 6'd31)
        |=> (bad_operand && result == $past(rt_val)));

    a_r7_ins_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd3 && fld_lo > fld_hi)
        |=> (bad_operand && result == $past(rt_val)));

    a_r8_half_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd4 && fld_lo == 5'h02)
        |=> (result[7:0] == $past(rt_val[15:8]) && !bad_operand));

    a_r10_undef_op: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 3'd4) |=> (bad_operand && result == $past(rt_val)));

endmodule

bind bfu_bitfield_unit bfu_bitfield_unit_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_sel      (op_sel),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .fld_hi      (fld_hi),
    .fld_lo      (fld_lo),
    .result      (result),
    .bad_operand (bad_operand)
);

// File: tb/bfu_bitfield_unit_tb_top.sv
`timescale 1ns/1ps
module bfu_bitfield_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [4:0]  fld_hi = '0;
    logic [4:0]  fld_lo = '0;
    logic [31:0] result;
    logic        bad_operand;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bfu_bitfield_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .rs_val(rs_val),
        .rt_val(rt_val), .fld_hi(fld_hi), .fld_lo(fld_lo),
        .result(result), .bad_operand(bad_operand)
    );

    // Reference model from the requirements: {bad, result}.
    function automatic logic [32:0] model(input logic [2:0] op, input logic [31:0] rs,
                                          input logic [31:0] rt, input int hi, input int lo);
        logic [31:0] r;
        int cnt;
        bit found;
        r = rt;
        case (op)
            3'd0, 3'd1: begin  // R2, R3
                cnt = 32; found = 0;
                for (int i = 31; i >= 0; i--)
                    if (!found && (rs[i] == (op == 3'd0))) begin cnt = 31 - i; found = 1; end
                return {1'b0, 32'(cnt)};
            end
            3'd2: begin  // R4, R6
                if (hi + lo > 31) return {1'b1, rt};
                r = '0;
                for (int i = 0; i <= hi; i++) r[i] = rs[lo + i];
                return {1'b0, r};
            end
            3'd3: begin  // R5, R7
                if (lo > hi) return {1'b1, rt};
                for (int i = lo; i <= hi; i++) r[i] = rs[i - lo];
                return {1'b0, r};
            end
            3'd4: begin  // R8, R9, R10
                if (lo == 5'h02) return {1'b0, rt[23:16], rt[31:24], rt[7:0], rt[15:8]};
                if (lo == 5'h10) return {1'b0, {24{rt[7]}}, rt[7:0]};
                if (lo == 5'h18) return {1'b0, {16{rt[15]}}, rt[15:0]};
                return {1'b1, rt};
            end
            default: return {1'b1, rt};  // R10
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op, input int hi, input int lo);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return (hi + lo > 31) ? "R6" : "R4";
            3'd3: return (lo > hi) ? "R7" : "R5";
            3'd4: return (lo == 5'h02) ? "R8" : ((lo == 5'h10 || lo == 5'h18) ? "R9" : "R10");
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual bad=%0b res=%08h expected bad=%0b res=%08h",
                     req, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    // Drive at a falling edge, sample at the following falling edge (R11).
    task automatic run(input logic [2:0] op, input logic [31:0] rs, input logic [31:0] rt,
                       input int hi, input int lo);
        @(negedge clk);
        op_sel = op; rs_val = rs; rt_val = rt; fld_hi = 5'(hi); fld_lo = 5'(lo);
        @(negedge clk);
        check(tag_of(op, hi, lo), {bad_operand, result}, model(op, rs, rt, hi, lo));
    endtask

    initial begin
        #(4ns * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0] op;
        logic [31:0] rs;
        logic [31:0] prev;
        int hi;
        int lo;
        void'($urandom(32'h5EED_0042));
        op_sel = 3'd3; rs_val = 32'hFFFF_FFFF; rt_val = 32'hA5A5_A5A5;
        repeat (3) @(negedge clk);
        check("R1", {bad_operand, result}, 33'd0);
        rst_n = 1'b1;

        // Directed corner cases.
        run(3'd0, 32'h0000_0000, 32'h1, 0, 0);
        run(3'd0, 32'h0000_0001, 32'h1, 0, 0);
        run(3'd0, 32'h8000_0000, 32'h1, 0, 0);
        run(3'd1, 32'hFFFF_FFFF, 32'h1, 0, 0);
        run(3'd1, 32'h7FFF_FFFF, 32'h1, 0, 0);
        run(3'd1, 32'hF000_0000, 32'h1, 0, 0);
        run(3'd2, 32'hDEAD_BEEF, 32'h1234_5678, 31, 0);
        run(3'd2, 32'h8000_0000, 32'h1234_5678, 0, 31);
        run(3'd2, 32'hDEAD_BEEF, 32'h1234_5678, 7, 24);
        run(3'd2, 32'hDEAD_BEEF, 32'h1234_5678, 8, 24);
        run(3'd3, 32'hCAFE_F00D, 32'h1234_5678, 31, 0);
        run(3'd3, 32'hFFFF_FFFF, 32'h0000_0000, 9, 9);
        run(3'd3, 32'h0000_000F, 32'hFFFF_FFFF, 31, 28);
        run(3'd3, 32'hCAFE_F00D, 32'h1234_5678, 3, 4);
        run(3'd4, 32'h0, 32'h1122_3344, 0, 5'h02);
        run(3'd4, 32'h0, 32'h0000_0080, 0, 5'h10);
        run(3'd4, 32'h0, 32'hFFFF_FF7F, 0, 5'h10);
        run(3'd4, 32'h0, 32'h0000_8001, 0, 5'h18);
        run(3'd4, 32'h0, 32'h1122_3344, 0, 5'h03);
        run(3'd7, 32'h0, 32'h1122_3344, 0, 0);

        // R11: output holds until the next rising edge.
        prev = result;
        @(negedge clk);
        op_sel = 3'd0; rs_val = 32'h0000_0100; rt_val = 32'h0; fld_hi = 0; fld_lo = 0;
        #1;
        check("R11", {bad_operand, result}, {1'b1, prev});
        @(negedge clk);
        check("R11", {bad_operand, result}, {1'b0, 32'd23});

        // Constrained random mix.
        for (int n = 0; n < 4000; n++) begin
            op = ($urandom_range(0, 9) < 9) ? 3'($urandom_range(0, 4)) : 3'($urandom_range(5, 7));
            rs = $urandom();
            if (op <= 3'd1 && $urandom_range(0, 1) == 1) begin
                rs = 32'hFFFF_FFFF >> $urandom_range(0, 31);
                if ($urandom_range(0, 8) == 0) rs = 32'h0;
                if (op == 3'd1) rs = ~rs;
            end
            hi = $urandom_range(0, 31);
            lo = $urandom_range(0, 31);
            if (op == 3'd4 && $urandom_range(0, 3) != 0) begin
                case ($urandom_range(0, 2))
                    0: lo = 5'h02;
                    1: lo = 5'h10;
                    default: lo = 5'h18;
                endcase
            end
            run(op, rs, $urandom(), hi, lo);
        end

        // R1: reset during operation clears the outputs.
        @(negedge clk);
        op_sel = 3'd6; rst_n = 1'b0;
        @(negedge clk);
        check("R1", {bad_operand, result}, 33'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule